// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block is a memory-mapped mailbox that lets several processors pass 32-bit words to one another. It holds a set of small hardware queues. A producer writes a word to a queue's message register. A consumer reads the same register to take the oldest word out. Each queue also has a full flag register and an occupancy register, so software can poll the queue without side effects.

Each queue raises two events: a new word has arrived, and space has just opened up. Every processor (a "user") has its own bank of three registers: status, enable and enable-clear. Status bits are cleared by writing a one to them. Enable bits are set through one register and cleared through another, so no read-modify-write is needed. Each user has one interrupt line, which is high while any status bit it has enabled is set.

The register bus is a plain single-cycle port. Read data is combinational from the address. A read strobe on a message register pops the queue at the next clock edge. Writes take effect at the clock edge on which the write strobe is high.

Top module: `ipc_mailbox`

## Requirements
- R1: Offset 0x000 reads the fixed revision constant (default 0x00000210). Any offset that is not a mapped register reads zero.
- R2: Queue m's message register is at 0x040 + 4*m. A write appends the word, and a read returns and removes the oldest word, in first-in first-out order. A read of an empty queue returns zero and changes nothing.
- R3: Queue m's occupancy register is at 0x0C0 + 4*m. It returns the number of stored words, and zero means empty.
- R4: Queue m's full register is at 0x080 + 4*m. It reads 1 when the queue holds its depth (default 4) of words and 0 otherwise. A write to a full queue is discarded and leaves the occupancy unchanged.
- R5: In every user register, bit 2*m is queue m's new-message event and bit 2*m+1 is its space-available event. User u's status register is at 0x104 + 0x10*u.
- R6: A push sets the new-message bit in every user's status. If a write of one clears that bit while the queue still holds words, the read right after the clear returns 0 and the next read returns 1. Once the queue is empty, the bit stays clear after the write.
- R7: The space-available bit is set only by a pop that takes a queue from full to not full. A pop from a queue that is not full leaves the bit unchanged.
- R8: In a status write, each one bit clears that status bit. Zero bits leave the status unchanged.
- R9: Writing ones at 0x108 + 0x10*u sets those enable bits of user u. Writing ones at 0x10C + 0x10*u clears them. Both offsets read back the current enable value.
- R10: User u's interrupt output is high exactly when some bit is set in both that user's status and enable registers. Each user's line is independent of the others.
- R11: Reset empties every queue and clears all status and enable bits, so every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops a queue when the address is a message register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 3 | One interrupt line per user |

## Verification
The hardest case to reach is the re-raise of a new-message bit. The bit is cleared by a write while words remain in the queue, and it must come back exactly one cycle later. The stimulus therefore reads status on the cycle after the clear and again on the following cycle, and checks for 0 and then 1. It then empties the queue and shows that the same clear sticks. The space-available event needs a queue filled to its depth, with a push beyond it that is discarded. The event is then checked against a pop from full and against a later pop that is not from full. A scoreboard tracks the expected contents of each queue, so every popped word and the dropped write are compared against it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned REV_OFS    = 'h000;
  localparam int unsigned MSG_BASE   = 'h040;
  localparam int unsigned FULL_BASE  = 'h080;
  localparam int unsigned CNT_BASE   = 'h0C0;
  localparam int unsigned USR_BASE   = 'h104;
  localparam int unsigned USR_STRIDE = 'h010;

  typedef enum logic [1:0] {
    UREG_STAT  = 2'd0,
    UREG_EN    = 2'd1,
    UREG_ENCLR = 2'd2
  } ureg_e;

  function automatic int unsigned msg_ofs(int unsigned m);
    return MSG_BASE + 4 * m;
  endfunction

  function automatic int unsigned full_ofs(int unsigned m);
    return FULL_BASE + 4 * m;
  endfunction

  function automatic int unsigned cnt_ofs(int unsigned m);
    return CNT_BASE + 4 * m;
  endfunction

  function automatic int unsigned usr_ofs(int unsigned u, ureg_e k);
    return USR_BASE + USR_STRIDE * u + 4 * 32'(k);
  endfunction

  function automatic int unsigned newmsg_bit(int unsigned m);
    return 2 * m;
  endfunction

  function automatic int unsigned notfull_bit(int unsigned m);
    return 2 * m + 1;
  endfunction

  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_from_full_o
);
  import mbox_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop_ok;

  assign full_o          = (count == CW'(DEPTH));
  assign empty_o         = (count == '0);
  assign push_ok_o       = push_i & ~full_o;
  assign pop_ok          = pop_i & ~empty_o;
  assign pop_from_full_o = pop_ok & full_o;
  assign count_o         = count;
  assign head_o          = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok_o) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok_o) wr_ptr <= PW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop_ok)    rd_ptr <= PW'(ring_next(32'(rd_ptr), DEPTH));
      case ({push_ok_o, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> $stable(count_o));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);

endmodule

// File: rtl/mbox_user_bank.sv
module mbox_user_bank #(
  parameter int NE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] pulse_i,
  input  logic [NE-1:0] level_i,
  input  logic          stat_wr_i,
  input  logic          en_wr_i,
  input  logic          enclr_wr_i,
  input  logic [NE-1:0] wdata_i,
  output logic [NE-1:0] stat_o,
  output logic [NE-1:0] en_o,
  output logic          irq_o
);

  logic [NE-1:0] stat_q, en_q, clr_mask, set_mask;

  assign clr_mask = stat_wr_i ? wdata_i : '0;
  assign set_mask = pulse_i | (level_i & ~clr_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_mask;
      if (en_wr_i)         en_q <= en_q | wdata_i;
      else if (enclr_wr_i) en_q <= en_q & ~wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);

  // R9
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

  // R9
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enclr_wr_i && !en_wr_i) |=> ((en_o & $past(wdata_i)) == '0));

  // R8
  w1c_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_i |=> (((stat_o ^ $past(stat_o)) & ~$past(wdata_i)
                    & ~$past(pulse_i | level_i)) == '0));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int          NUM_Q     = 4,
  parameter int          Q_DEPTH   = 4,
  parameter int          NUM_USERS = 3,
  parameter int          DW        = 32,
  parameter int          AW        = 9,
  parameter logic [31:0] REV_ID    = 32'h0000_0210
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [NUM_USERS-1:0] irq
);
  import mbox_pkg::*;

  localparam int NE = 2 * NUM_Q;
  localparam int CW = $clog2(Q_DEPTH + 1);

  logic [NUM_Q-1:0] msg_hit, full_hit, cnt_hit;
  logic [NUM_Q-1:0] qpush, qpop, qfull, qempty, qpush_ok, qpff;
  logic [DW-1:0]    qhead [NUM_Q];
  logic [CW-1:0]    qcnt  [NUM_Q];

  logic [NUM_USERS-1:0] st_hit, en_hit, enclr_hit;
  logic [NE-1:0]        ust [NUM_USERS];
  logic [NE-1:0]        uen [NUM_USERS];
  logic [NE-1:0]        evt_pulse, evt_level;

  for (genvar m = 0; m < NUM_Q; m++) begin : g_q
    assign msg_hit[m]  = (32'(bus_addr) == msg_ofs(m));
    assign full_hit[m] = (32'(bus_addr) == full_ofs(m));
    assign cnt_hit[m]  = (32'(bus_addr) == cnt_ofs(m));
    assign qpush[m]    = bus_wr & msg_hit[m];
    assign qpop[m]     = bus_rd & msg_hit[m];

    mbox_queue #(.DW(DW), .DEPTH(Q_DEPTH), .CW(CW)) u_queue (
      .clk             (clk),
      .rst_n           (rst_n),
      .push_i          (qpush[m]),
      .pop_i           (qpop[m]),
      .wdata_i         (bus_wdata),
      .head_o          (qhead[m]),
      .count_o         (qcnt[m]),
      .full_o          (qfull[m]),
      .empty_o         (qempty[m]),
      .push_ok_o       (qpush_ok[m]),
      .pop_from_full_o (qpff[m])
    );
  end

  always_comb begin
    evt_pulse = '0;
    evt_level = '0;
    for (int m = 0; m < NUM_Q; m++) begin
      evt_pulse[2*m]   = qpush_ok[m];
      evt_pulse[2*m+1] = qpff[m];
      evt_level[2*m]   = ~qempty[m];
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_usr
    assign st_hit[u]    = (32'(bus_addr) == usr_ofs(u, UREG_STAT));
    assign en_hit[u]    = (32'(bus_addr) == usr_ofs(u, UREG_EN));
    assign enclr_hit[u] = (32'(bus_addr) == usr_ofs(u, UREG_ENCLR));

    mbox_user_bank #(.NE(NE)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .pulse_i    (evt_pulse),
      .level_i    (evt_level),
      .stat_wr_i  (bus_wr & st_hit[u]),
      .en_wr_i    (bus_wr & en_hit[u]),
      .enclr_wr_i (bus_wr & enclr_hit[u]),
      .wdata_i    (bus_wdata[NE-1:0]),
      .stat_o     (ust[u]),
      .en_o       (uen[u]),
      .irq_o      (irq[u])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (32'(bus_addr) == REV_OFS) bus_rdata = DW'(REV_ID);
    for (int m = 0; m < NUM_Q; m++) begin
      if (msg_hit[m])  bus_rdata = qhead[m];
      if (full_hit[m]) bus_rdata = DW'(qfull[m]);
      if (cnt_hit[m])  bus_rdata = DW'(qcnt[m]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (st_hit[u])                bus_rdata = DW'(ust[u]);
      if (en_hit[u] | enclr_hit[u]) bus_rdata = DW'(uen[u]);
    end
  end

  for (genvar m = 0; m < NUM_Q; m++) begin : g_chk_q
    localparam int NB = 2 * m;
    localparam int FB = 2 * m + 1;
    for (genvar u = 0; u < NUM_USERS; u++) begin : g_chk_u
      // R7
      notfull_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qpff[m] |=> ust[u][FB]);

      // R6
      newmsg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qempty[m] && !(bus_wr && st_hit[u] && bus_wdata[NB])) |=> ust[u][NB]);
    end
  end

endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] sb [4][$];

  always #10 clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [8:0] a_msg(int m);   return 9'('h40 + 4*m); endfunction
  function automatic logic [8:0] a_full(int m);  return 9'('h80 + 4*m); endfunction
  function automatic logic [8:0] a_cnt(int m);   return 9'('hC0 + 4*m); endfunction
  function automatic logic [8:0] a_st(int u);    return 9'('h104 + 'h10*u); endfunction
  function automatic logic [8:0] a_en(int u);    return 9'('h108 + 'h10*u); endfunction
  function automatic logic [8:0] a_enclr(int u); return 9'('h10C + 'h10*u); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  // driver: pushes the expected word into the scoreboard when the queue has room
  task automatic push_msg(input int m, input logic [31:0] d);
    bus_write(a_msg(m), d);
    if (sb[m].size() < 4) sb[m].push_back(d);
  endtask

  // monitor: pops from the design and compares against the scoreboard
  task automatic pop_check(input int m, input string tag);
    logic [31:0] d, exp;
    bus_read(a_msg(m), d);
    exp = (sb[m].size() > 0) ? sb[m].pop_front() : 32'h0;
    check(tag, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) sb[m].delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R11 reset state, R1 revision and unmapped offsets
    check("R11 irq after reset", 32'(irq), 32'h0);
    read_check("R1 revision", 9'h000, 32'h0000_0210);
    read_check("R1 unmapped 0x004", 9'h004, 32'h0);
    read_check("R1 unmapped 0x03C", 9'h03C, 32'h0);
    read_check("R11 count q0 after reset", a_cnt(0), 32'h0);
    read_check("R11 status u2 after reset", a_st(2), 32'h0);

    // R2/R3/R5 pushes into queue 0
    push_msg(0, 32'h1111_0001);
    push_msg(0, 32'h2222_0002);
    push_msg(0, 32'h3333_0003);
    read_check("R3 count q0", a_cnt(0), 32'd3);
    read_check("R4 full q0 not full", a_full(0), 32'h0);
    read_check("R5 status u0 newmsg q0", a_st(0), 32'h1);

    // R4 fill queue 2, drop extra write
    for (int i = 0; i < 5; i++) push_msg(2, 32'hC0DE_0000 + 32'(i));
    read_check("R4 full q2", a_full(2), 32'h1);
    read_check("R4 count q2 after dropped write", a_cnt(2), 32'd4);
    read_check("R5 status u1 bits for q0 and q2", a_st(1), 32'h11);

    // R9 / R10 enables and interrupt lines
    bus_write(a_en(1), 32'h10);
    check("R10 irq u1 raised", 32'(irq), 32'b010);
    bus_write(a_en(1), 32'h01);
    read_check("R9 enable u1 accumulates", a_en(1), 32'h11);
    bus_write(a_enclr(1), 32'h10);
    read_check("R9 enable u1 after clear", a_enclr(1), 32'h01);
    check("R10 irq u1 still from q0", 32'(irq), 32'b010);
    bus_write(a_enclr(1), 32'h01);
    check("R10 irq u1 dropped", 32'(irq), 32'b000);

    // R7 not-full event
    pop_check(2, "R2 q2 pop first");
    read_check("R7 status u2 space bit q2", a_st(2) , 32'h31);
    bus_write(a_st(2), 32'h20);
    read_check("R8 status u2 after clearing bit5", a_st(2), 32'h11);
    pop_check(2, "R2 q2 pop second");
    read_check("R7 no space event from non-full pop", a_st(2), 32'h11);

    // R8 zero write keeps status
    bus_write(a_st(0), 32'h0);
    read_check("R8 zero write keeps status u0", a_st(0), 32'h31);

    // R6 re-raise while words remain
    bus_write(a_st(0), 32'h1);
    read_check("R6 newmsg cleared cycle after write", a_st(0), 32'h30);
    read_check("R6 newmsg re-raised", a_st(0), 32'h31);

    // R2 drain queue 0 in order, then clear sticks
    pop_check(0, "R2 q0 word 1");
    pop_check(0, "R2 q0 word 2");
    pop_check(0, "R2 q0 word 3");
    bus_write(a_st(0), 32'h1);
    read_check("R6 cleared on empty queue", a_st(0), 32'h30);
    read_check("R6 stays clear on empty queue", a_st(0), 32'h30);
    pop_check(0, "R2 empty read returns zero");
    read_check("R2 empty read leaves count", a_cnt(0), 32'h0);

    // R2 data patterns on queue 3
    push_msg(3, 32'hFFFF_FFFF);
    push_msg(3, 32'h0000_0000);
    push_msg(3, 32'hA5A5_A5A5);
    push_msg(3, 32'h5A5A_5A5A);
    read_check("R4 full q3", a_full(3), 32'h1);
    for (int i = 0; i < 4; i++) pop_check(3, "R2 q3 pattern");
    read_check("R3 q3 empty count", a_cnt(3), 32'h0);

    // R10 independent users
    bus_write(a_en(0), 32'hFF);
    check("R10 only u0 line high", 32'(irq), 32'b001);

    // R11 reset mid-run
    do_reset();
    read_check("R11 count q2 cleared", a_cnt(2), 32'h0);
    read_check("R11 enable u0 cleared", a_en(0), 32'h0);
    read_check("R11 status u0 cleared", a_st(0), 32'h0);
    check("R11 irq cleared", 32'(irq), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule